// File: doc/BRIEF.md
# Seven-Source Interrupt Enable and Status Unit

This block gathers seven interrupt requests into one host interrupt line. Four requests come from the handshake lines of two parallel ports and three come from counter outputs. Each request passes through a synchronizer and an edge detector. When a request rises and its source is enabled, the block records the event in a sticky status bit. The interrupt output is high while any status bit is set.

The host reaches two 8-bit registers over a simple register bus. Writes take effect on the clock edge. Reads are combinational from the address.

- **Enable register (offset 0xC, read/write).** A 1 in a bit lets that source interrupt.
- **Status register (offset 0xD, read-only).** It shows which sources have fired.

Status is not cleared by writing the status register. To clear a serviced source, the host writes its enable bit to 0 and then writes it back to 1.

Top module: `irq_combiner`

## Requirements
- R1: After reset, the enable register and the status register both read 0x00 and `irqOut` is low.
- R2: A write to offset 0xC stores bits 6:0 as the enable mask. A read of 0xC returns that mask with bit 7 reading 0.
- R3: Offset 0xD returns the status in bits 6:0 with bit 7 at 0. A write to 0xD changes neither register.
- R4: Status bit i is set by a rising edge on `srcReq[i]` while enable bit i is 1. The bit positions are: bits 0 and 1 for the first port's two handshake lines, bits 2 and 3 for the second port's two lines, and bits 4, 5 and 6 for counters 0, 1 and 2. The bit reads as set three clock edges after the request is first sampled high.
- R5: A rising edge on a source whose enable bit is 0 leaves its status bit at 0.
- R6: A status bit stays set after its request falls, until it is cleared.
- R7: Writing enable bit i to 0 clears status bit i within two edges after the write edge. Other status bits are not affected.
- R8: `irqOut` is high exactly when at least one status bit is set.
- R9: Offsets other than 0xC and 0xD read as 0x00, and writes to them are ignored.
- R10: A request that is already high when its enable bit goes from 0 to 1 does not set status. Only a later rising edge does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 4 | Register offset |
| regWrEn | input | 1 | Write strobe |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Read data (combinational) |
| srcReq | input | 7 | Asynchronous source requests |
| irqOut | output | 1 | Combined interrupt |

## Verification
The assertions check two rules on every cycle:
- a status bit can only newly set after an enabled rising edge was seen, and a disabled bit is clear one edge later;
- the interrupt output agrees with the status register, and bit 7 of the read data is always 0.

Other behaviours only the bench scenarios can show:
- the exact three-edge latency;
- the fixed mapping of source bits;
- the read-only nature of the status offset;
- the fact that a level held across re-enabling does not fire.

// File: rtl/irq_combiner_pkg.sv
package irq_combiner_pkg;
  localparam int NUM_SRC = 7;
  localparam int ADDR_W  = 4;
  localparam int DATA_W  = 8;

  typedef struct packed {
    logic wrEnable;
    logic rdEnable;
    logic rdStatus;
  } regStrobeT;
endpackage

// File: rtl/irq_combiner_ctrl.sv
module irq_combiner_ctrl
  import irq_combiner_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter logic [AW-1:0] ENABLE_OFS = 4'hC,
  parameter logic [AW-1:0] STATUS_OFS = 4'hD
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [AW-1:0] regAddr,
  input  logic          regWrEn,
  output regStrobeT     strobe
);
  always_comb begin
    strobe          = '0;
    strobe.wrEnable = regWrEn && (regAddr == ENABLE_OFS);
    strobe.rdEnable = (regAddr == ENABLE_OFS);
    strobe.rdStatus = (regAddr == STATUS_OFS);
  end

  AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.rdEnable, strobe.rdStatus})); // R9
endmodule

// File: rtl/irq_combiner_datapath.sv
module irq_combiner_datapath
  import irq_combiner_pkg::*;
#(
  parameter int NS = NUM_SRC,
  parameter int DW = DATA_W,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  regStrobeT     strobe,
  input  logic [DW-1:0] regWrData,
  input  logic [NS-1:0] srcReq,
  output logic [DW-1:0] regRdData,
  output logic          irqOut
);
  localparam int PAD_W = DW - NS;

  logic [NS-1:0] syncLast;
  logic [NS-1:0] prevLevel;
  logic [NS-1:0] riseVec;
  logic [NS-1:0] enableQ;
  logic [NS-1:0] statusQ;
  logic [NS-1:0] statusNext;

  genvar gi;
  generate
    for (gi = 0; gi < NS; gi++) begin : g_sync
      logic [SYNC_STAGES-1:0] chain;
      always_ff @(posedge clk) begin
        if (!rstN) chain <= '0;
        else       chain <= {chain[SYNC_STAGES-2:0], srcReq[gi]};
      end
      assign syncLast[gi] = chain[SYNC_STAGES-1];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) prevLevel <= '0;
    else       prevLevel <= syncLast;
  end

  assign riseVec    = syncLast & ~prevLevel;
  assign statusNext = (statusQ | (riseVec & enableQ)) & enableQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enableQ <= '0;
      statusQ <= '0;
      irqOut  <= 1'b0;
    end else begin
      if (strobe.wrEnable) enableQ <= regWrData[NS-1:0];
      statusQ <= statusNext;
      irqOut  <= |statusNext;
    end
  end

  always_comb begin
    regRdData = '0;
    if (strobe.rdEnable)      regRdData = {{PAD_W{1'b0}}, enableQ};
    else if (strobe.rdStatus) regRdData = {{PAD_W{1'b0}}, statusQ};
  end

  AST_SET_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((statusQ & ~$past(statusQ) & ~$past(riseVec & enableQ)) == '0)); // R4
  AST_DISABLED_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((statusQ & ~$past(enableQ)) == '0)); // R7
  AST_IRQ_MATCHES: assert property (@(posedge clk) disable iff (!rstN)
    irqOut == (statusQ != '0)); // R8
endmodule

// File: rtl/irq_combiner.sv
module irq_combiner
  import irq_combiner_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic [NUM_SRC-1:0] srcReq,
  output logic              irqOut
);
  regStrobeT strobe;

  irq_combiner_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn), .strobe(strobe)
  );

  irq_combiner_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .regWrData(regWrData),
    .srcReq(srcReq), .regRdData(regRdData), .irqOut(irqOut)
  );

  AST_BIT7_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    regRdData[DATA_W-1] == 1'b0); // R2
endmodule

// File: tb/irq_combiner_bench.sv
module irq_combiner_bench;
  logic       clk = 0;
  logic       rstN = 0;
  logic [3:0] regAddr = 0;
  logic       regWrEn = 0;
  logic [7:0] regWrData = 0;
  logic [7:0] regRdData;
  logic [6:0] srcReq = 0;
  logic       irqOut;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  irq_combiner u_irq_combiner (.*);

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    @(negedge clk); regAddr = a; regWrData = d; regWrEn = 1;
    @(negedge clk); regWrEn = 0;
  endtask

  task automatic rd(logic [3:0] a, output logic [7:0] d);
    @(negedge clk); regAddr = a; #1 d = regRdData;
  endtask

  task automatic pulse(logic [6:0] m);
    @(negedge clk); srcReq = srcReq | m;
    repeat (3) @(negedge clk);
    srcReq = srcReq & ~m;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk); rstN = 1;
    rd(4'hC, d); check("R1 enable", d, 8'h00);
    rd(4'hD, d); check("R1 status", d, 8'h00);
    check("R1 irq", {7'b0, irqOut}, 8'h00);

    wr(4'hC, 8'hFF); rd(4'hC, d); check("R2 readback bit7", d, 8'h7F);
    wr(4'hC, 8'h2A); rd(4'hC, d); check("R2 readback", d, 8'h2A);

    for (int i = 0; i < 7; i++) begin
      wr(4'hC, 8'h7F);
      pulse(7'(1 << i));
      rd(4'hD, d); check("R4 set bit", d, 8'(1 << i));
      check("R8 irq set", {7'b0, irqOut}, 8'h01);
      repeat (4) @(negedge clk);
      rd(4'hD, d); check("R6 hold", d, 8'(1 << i));
      wr(4'hD, 8'h00); rd(4'hD, d); check("R3 status ro", d, 8'(1 << i));
      wr(4'hC, 8'(7'h7F & ~(7'(1 << i)))); @(negedge clk);
      rd(4'hD, d); check("R7 clear", d, 8'h00);
      check("R8 irq clear", {7'b0, irqOut}, 8'h00);
      pulse(7'(1 << i)); @(negedge clk);
      rd(4'hD, d); check("R5 disabled", d, 8'h00);
    end

    wr(4'hC, 8'h7F);
    pulse(7'h55); rd(4'hD, d); check("R4 multi", d, 8'h55);
    wr(4'hC, 8'h7E); @(negedge clk);
    rd(4'hD, d); check("R7 selective clear", d, 8'h54);
    check("R8 irq multi", {7'b0, irqOut}, 8'h01);
    wr(4'hC, 8'h00); @(negedge clk);

    wr(4'h3, 8'h7F); rd(4'hC, d); check("R9 write ignored", d, 8'h00);
    for (int a = 0; a < 16; a++) begin
      if (a != 12 && a != 13) begin
        rd(4'(a), d); check("R9 other offset", d, 8'h00);
      end
    end

    @(negedge clk); srcReq = 7'h08;
    repeat (4) @(negedge clk);
    wr(4'hC, 8'h08); repeat (4) @(negedge clk);
    rd(4'hD, d); check("R10 level no set", d, 8'h00);
    srcReq = 0; repeat (3) @(negedge clk);
    pulse(7'h08); rd(4'hD, d); check("R10 later edge", d, 8'h08);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule